// File: doc/BRIEF.md
# Key Auto-Zeroise Timeout Controller

This block holds a secret key of up to 256 bits and clears it once the key has gone unused for a programmable number of clock cycles. Software writes a key and a timeout start value. While a key is loaded, a down-counter decrements on every idle cycle. When the counter has reached zero and one more idle cycle passes, the key, the valid status and every other key bit are wiped in a single clock edge, and an expiry flag is raised.

The countdown is frozen while the wrap engine reports busy. It is reloaded when the engine finishes an operation, when software reads status, or when a new key is written. Polling status is therefore enough to keep a key alive. Software can also force an immediate wipe. A forced wipe wins over a key write in the same cycle, and it does not raise the expiry flag.

Top module: `key_zeroise_ctrl`

## Requirements
- R1: After reset, key_o is all zero, key_valid_o is 0, tmo_flag_o is 0, and the timeout register holds DEF_TIMEOUT.
- R2: A key write with no forced zeroise in the same cycle has these effects from the next cycle: key_o equals the written key, key_valid_o is 1 and tmo_flag_o is 0. It also reloads the countdown with the timeout register value held before that edge.
- R3: With timeout value T, a loaded key and only idle cycles (busy_i low, no status read, no writes), the key survives T idle edges after the load and is wiped on the (T+1)th. In the cycle after the wipe, key_o is all zero across its full width, key_valid_o is 0 and tmo_flag_o is 1.
- R4: While busy_i is high, the countdown holds its value and no expiry wipe happens.
- R5: An idle cycle in which busy_i is low after being high in the previous cycle reloads the countdown instead of decrementing it.
- R6: A status-read strobe while a key is loaded and busy_i is low reloads the countdown, so polling at intervals of at most T+1 cycles keeps the key alive.
- R7: A forced zeroise gives key_o all zero, key_valid_o 0 and tmo_flag_o 0 in the next cycle. This holds even when a key write is strobed in the same cycle.
- R8: A write to the timeout register does not change a running countdown. It takes effect at the next reload.
- R9: While no key is loaded, nothing expires and tmo_flag_o keeps its value. The counter stays at the timeout register value, so the next key load starts a full countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| key_we_i | input | 1 | Key write strobe |
| key_i | input | KEY_W | Key data to load |
| tmo_we_i | input | 1 | Timeout register write strobe |
| tmo_i | input | CNT_W | Timeout start value in cycles |
| stat_rd_i | input | 1 | Status read strobe; reloads the countdown |
| zeroise_i | input | 1 | Forced zeroise command |
| busy_i | input | 1 | Wrap/unwrap engine busy |
| key_o | output | KEY_W | Current key register contents |
| key_valid_o | output | 1 | A key is loaded |
| tmo_flag_o | output | 1 | Last wipe was caused by timeout expiry |

## Verification
A counter that is off by one shows up as a wipe one cycle early or late. The bench sees this as a mismatch on key_valid_o and key_o on the exact edge, because a behavioural model is compared on every clock. A countdown that is not frozen, or not reloaded, by busy or by a status read only shows at the end of the window, when the key disappears too early or survives too long. The sequences therefore run each window right up to the predicted expiry edge. A wrong priority between a forced wipe and a key write shows one cycle after the collision, as a nonzero key_o.

// File: rtl/kz_pkg.sv
package kz_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_LOAD = 2'd1,
    CNT_DEC  = 2'd2
  } cnt_act_e;
endpackage

// File: rtl/kz_countdown.sv
module kz_countdown
  import kz_pkg::*;
#(
  parameter int unsigned      CNT_W = 32,
  parameter logic [CNT_W-1:0] RST_V = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_act_e         act_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= RST_V;
    else begin
      unique case (act_i)
        CNT_LOAD: cnt_q <= load_val_i;
        CNT_DEC:  cnt_q <= cnt_q - 1'b1;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == CNT_DEC) |-> (cnt_q != '0)); // R3
endmodule

// File: rtl/kz_key_reg.sv
module kz_key_reg #(
  parameter int unsigned KEY_W = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_we_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             zeroise_i,
  input  logic             expire_i,
  output logic [KEY_W-1:0] key_o,
  output logic             valid_o,
  output logic             flag_o
);
  logic [KEY_W-1:0] key_q;
  logic             valid_q, flag_q;

  // priority: forced wipe > load > expiry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q   <= '0;
      valid_q <= 1'b0;
      flag_q  <= 1'b0;
    end else if (zeroise_i) begin
      key_q   <= '0;
      valid_q <= 1'b0;
      flag_q  <= 1'b0;
    end else if (key_we_i) begin
      key_q   <= key_i;
      valid_q <= 1'b1;
      flag_q  <= 1'b0;
    end else if (expire_i) begin
      key_q   <= '0;
      valid_q <= 1'b0;
      flag_q  <= 1'b1;
    end
  end

  assign key_o   = key_q;
  assign valid_o = valid_q;
  assign flag_o  = flag_q;

  AST_WIPE_ON_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && !zeroise_i && !key_we_i) |=> (key_q == '0 && !valid_q && flag_q)); // R3
  AST_FORCE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zeroise_i |=> (key_q == '0 && !valid_q && !flag_q)); // R7
  AST_LOAD_SETS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_we_i && !zeroise_i) |=> (valid_q && !flag_q && key_q == $past(key_i))); // R2
  AST_FLAG_STABLE_NO_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_q && !zeroise_i && !key_we_i) |=> $stable(flag_q)); // R9
endmodule

// File: rtl/key_zeroise_ctrl.sv
module key_zeroise_ctrl
  import kz_pkg::*;
#(
  parameter int unsigned      KEY_W       = 256,
  parameter int unsigned      CNT_W       = 32,
  parameter logic [CNT_W-1:0] DEF_TIMEOUT = CNT_W'(1000)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_we_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             tmo_we_i,
  input  logic [CNT_W-1:0] tmo_i,
  input  logic             stat_rd_i,
  input  logic             zeroise_i,
  input  logic             busy_i,
  output logic [KEY_W-1:0] key_o,
  output logic             key_valid_o,
  output logic             tmo_flag_o
);
  logic [CNT_W-1:0] tmo_val_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, busy_fall, cnt_zero, expire;
  cnt_act_e         cnt_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_val_q <= DEF_TIMEOUT;
      busy_q    <= 1'b0;
    end else begin
      if (tmo_we_i) tmo_val_q <= tmo_i;
      busy_q <= busy_i;
    end
  end

  assign busy_fall = busy_q && !busy_i;

  always_comb begin
    cnt_act = CNT_DEC;
    expire  = 1'b0;
    if (zeroise_i || key_we_i || !key_valid_o) cnt_act = CNT_LOAD;
    else if (busy_i)                          cnt_act = CNT_HOLD;
    else if (stat_rd_i || busy_fall)          cnt_act = CNT_LOAD;
    else if (cnt_zero) begin
      cnt_act = CNT_LOAD;
      expire  = 1'b1;
    end
  end

  kz_countdown #(.CNT_W(CNT_W), .RST_V(DEF_TIMEOUT)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (cnt_act),
    .load_val_i (tmo_val_q),
    .cnt_o      (cnt_q),
    .zero_o     (cnt_zero)
  );

  kz_key_reg #(.KEY_W(KEY_W)) u_key (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .key_we_i  (key_we_i),
    .key_i     (key_i),
    .zeroise_i (zeroise_i),
    .expire_i  (expire),
    .key_o     (key_o),
    .valid_o   (key_valid_o),
    .flag_o    (tmo_flag_o)
  );

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_valid_o && busy_i && !zeroise_i && !key_we_i) |=> $stable(cnt_q)); // R4
  AST_NO_WIPE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_valid_o && busy_i && !zeroise_i) |=> key_valid_o); // R4
  AST_DONE_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_valid_o && busy_fall && !zeroise_i && !key_we_i) |=> (cnt_q == $past(tmo_val_q))); // R5
  AST_POLL_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_valid_o && stat_rd_i && !busy_i && !zeroise_i && !key_we_i) |=> (cnt_q == $past(tmo_val_q))); // R6
  AST_IDLE_NO_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_valid_o |-> !expire); // R9
endmodule

// File: tb/tb_key_zeroise_ctrl.sv
`timescale 1ns/1ps
module tb_key_zeroise_ctrl;
  localparam int unsigned KEY_W = 256;
  localparam int unsigned CNT_W = 32;
  localparam int unsigned DEF_T = 40;

  logic             clk = 1'b0, rst_n = 1'b0;
  logic             key_we = 0, tmo_we = 0, stat_rd = 0, zeroise = 0, busy = 0;
  logic [KEY_W-1:0] key_d = '0;
  logic [CNT_W-1:0] tmo_d = '0;
  logic [KEY_W-1:0] key_o;
  logic             valid_o, flag_o;

  always #10 clk = ~clk; // 50 MHz

  key_zeroise_ctrl #(.KEY_W(KEY_W), .CNT_W(CNT_W), .DEF_TIMEOUT(CNT_W'(DEF_T))) dut (
    .clk_i(clk), .rst_ni(rst_n), .key_we_i(key_we), .key_i(key_d),
    .tmo_we_i(tmo_we), .tmo_i(tmo_d), .stat_rd_i(stat_rd), .zeroise_i(zeroise),
    .busy_i(busy), .key_o(key_o), .key_valid_o(valid_o), .tmo_flag_o(flag_o)
  );

  // behavioural reference
  logic [KEY_W-1:0] m_key = '0;
  bit               m_valid = 0, m_flag = 0, m_busy_prev = 0;
  longint           m_tmo = DEF_T, m_left = DEF_T;
  int               n_cmp = 0, n_bad = 0;
  string            phase = "R1";

  always @(posedge clk) begin
    if (rst_n) begin
      bit reload_next;
      longint tmo_before;
      tmo_before  = m_tmo;
      reload_next = 0;
      if (tmo_we) m_tmo = tmo_d;
      if (zeroise) begin
        m_key = '0; m_valid = 0; m_flag = 0; m_left = tmo_before;
      end else if (key_we) begin
        m_key = key_d; m_valid = 1; m_flag = 0; m_left = tmo_before;
      end else if (!m_valid) begin
        m_left = tmo_before;
      end else if (busy) begin
        reload_next = 0;
      end else if (stat_rd || m_busy_prev) begin
        m_left = tmo_before;
      end else if (m_left == 0) begin
        m_key = '0; m_valid = 0; m_flag = 1; m_left = tmo_before;
      end else begin
        m_left--;
      end
      m_busy_prev = busy;
    end
  end

  task automatic chk(string tag);
    n_cmp++;
    if (key_o !== m_key || valid_o !== m_valid || flag_o !== m_flag) begin
      n_bad++;
      $display("FAIL %s t=%0t: valid=%b flag=%b key=%h expected valid=%b flag=%b key=%h",
               tag, $time, valid_o, flag_o, key_o, m_valid, m_flag, m_key);
    end
  endtask

  always @(negedge clk) if (rst_n) chk(phase);

  function automatic logic [KEY_W-1:0] mk_key(int s);
    logic [KEY_W-1:0] k;
    for (int i = 0; i < KEY_W/32; i++) k[i*32 +: 32] = 32'h9E3779B9 * (s + i + 1) ^ 32'h5A5A0000;
    return k;
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic strobe_key(int s);
    key_we = 1; key_d = mk_key(s); idle(1); key_we = 0;
  endtask

  task automatic strobe_tmo(int v);
    tmo_we = 1; tmo_d = CNT_W'(v); idle(1); tmo_we = 0;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #45 rst_n = 1;
    idle(1);
    // R1 reset values
    phase = "R1"; idle(2);
    // R1: default timeout used on first load; R3 expiry at DEF_T+1 idle edges
    phase = "R3"; strobe_key(1); idle(DEF_T + 4);
    // R2 load then short timeout R3 exact edge
    phase = "R2"; strobe_tmo(5); strobe_key(2); idle(2);
    phase = "R3"; idle(8);
    // R4 busy freezes, R5 done reloads
    phase = "R4"; strobe_tmo(6); strobe_key(3); idle(3);
    busy = 1; idle(30);
    phase = "R5"; busy = 0; idle(5);
    busy = 1; idle(2); busy = 0; idle(10);
    // R6 polling keeps alive
    phase = "R6"; strobe_tmo(4); strobe_key(4);
    for (int i = 0; i < 8; i++) begin
      idle(4); stat_rd = 1; idle(1); stat_rd = 0;
    end
    idle(8);
    // R7 forced zeroise, and against simultaneous key write
    phase = "R7"; strobe_tmo(50); strobe_key(5); idle(3);
    zeroise = 1; idle(1); zeroise = 0; idle(2);
    zeroise = 1; key_we = 1; key_d = mk_key(6); idle(1); zeroise = 0; key_we = 0; idle(2);
    strobe_key(7); zeroise = 1; busy = 1; idle(1); zeroise = 0; busy = 0; idle(3);
    // R8 timeout change mid-count applies at next reload
    phase = "R8"; strobe_tmo(10); strobe_key(8); idle(3); strobe_tmo(3);
    idle(4); stat_rd = 1; idle(1); stat_rd = 0; idle(6);
    // R9 no key: nothing expires, flag retained, load gets full count
    phase = "R9"; strobe_tmo(2); idle(20); strobe_tmo(7); idle(3);
    strobe_key(9); idle(12);
    strobe_tmo(0); strobe_key(10); idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule